// File: doc/BRIEF.md
# Stop-Clock Power State Sequencer

This block puts a processor core into a low-power clock-stopped state on request and brings it back out. An asynchronous stop request is passed through a synchronizer. Once the request is taken, the block raises an acknowledge request on a simple bus handshake and holds it until the bus interface strobes done. After that it turns off the clock enables of every core unit. The clock enables for the bus unit and the interrupt controller, and the snoop enable, stay high in every state. The bus clock is never gated.

Interrupt requests are captured into a pending register in every state, so none that arrive during the stop are lost. When the stop request is released, the core clock enables come back on for a one-cycle wake step. The block then returns to normal running and flags the pending interrupts for service. The core clears each pending bit with its own service acknowledge.

Top module: `scs_top`

## Requirements
- R1: The stop request passes through two synchronizer stages. A request that is high before clock edges 1 and 2 is acted on at edge 3, where `ackReq` rises. Before that edge `ackReq` stays low.
- R2: `ackReq` stays high until `busDone` is sampled high, and it falls at that same edge. Each accepted request produces exactly one acknowledge.
- R3: If the synchronized request is still high when `busDone` is sampled, every bit of `coreClkEn` goes low at that edge. The bits stay low for as long as the stopped state lasts.
- R4: `busClkEn`, `intcClkEn` and `snoopEn` are high in every state, including reset.
- R5: A high `intReq[i]` sets `pendingInt[i]` at the next clock edge, in any state.
- R6: A pending bit is cleared only by `intAck[i]` outside the stopped state. Acknowledges that arrive while stopped are ignored. When a request and an acknowledge for the same bit arrive together, the bit stays set.
- R7: A release is seen two edges after the request goes low. At the next edge `coreClkEn` returns to all ones for a one-cycle wake step. `intValid` is high only in the run state, and only while `pendingInt` is nonzero.
- R8: If the request is released before `busDone`, the acknowledge still completes. The block then goes straight to the wake step, and `coreClkEn` never goes low.
- R9: During reset, `ackReq` and `intValid` are low, `pendingInt` is zero and `coreClkEn` is all ones. Interrupt requests made during reset are not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, never gated |
| rstN | input | 1 | Active-low synchronous reset |
| stopReqAsync | input | 1 | Asynchronous stop request |
| busDone | input | 1 | Bus interface has finished the acknowledge |
| intReq | input | NUM_INT | Interrupt request pulses |
| intAck | input | NUM_INT | Per-bit service acknowledge from the core |
| ackReq | output | 1 | Acknowledge transaction request |
| coreClkEn | output | NUM_CORE | Clock enables for the core units |
| busClkEn | output | 1 | Bus unit clock enable |
| intcClkEn | output | 1 | Interrupt controller clock enable |
| snoopEn | output | 1 | Snoop logic enable |
| pendingInt | output | NUM_INT | Pending interrupt register |
| intValid | output | 1 | Pending interrupts offered for service |

## Verification
The assertions assume that `busDone` is only driven while `ackReq` is high. They also assume the core only acknowledges bits that it sees pending. The stimulus pulses `busDone` only after it has observed `ackReq`, and it acknowledges only bits shown on `pendingInt`. Every input changes on the falling clock edge. The asynchronous request is therefore stable at each sampling edge, which makes the synchronizer latency deterministic.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_ACK_WAIT = 2'd1,
    ST_STOPPED  = 2'd2,
    ST_WAKE     = 2'd3
  } scsState_t;

  typedef struct packed {
    logic coreOn;    // core clock enables for the next cycle
    logic clearOk;   // service acknowledges may clear pending bits
    logic serviceOk; // pending interrupts may be offered
  } scsStrobe_t;
endpackage

// File: rtl/scs_ctrl.sv
module scs_ctrl
  import scs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopSync,
  input  logic       busDone,
  output logic       ackReq,
  output scsStrobe_t strobe
);
  scsState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RUN:      if (stopSync) nextState = ST_ACK_WAIT;
      ST_ACK_WAIT: if (busDone) nextState = stopSync ? ST_STOPPED : ST_WAKE;
      ST_STOPPED:  if (!stopSync) nextState = ST_WAKE;
      ST_WAKE:     nextState = ST_RUN;
      default:     nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  assign ackReq           = (state == ST_ACK_WAIT);
  assign strobe.coreOn    = (nextState != ST_STOPPED);
  assign strobe.clearOk   = (state != ST_STOPPED);
  assign strobe.serviceOk = (state == ST_RUN);

  // R2
  ack_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && !busDone) |=> ackReq);

  // R2
  ack_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && busDone) |=> !ackReq);

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOPPED && stopSync) |=> (state == ST_STOPPED));

  // R7
  wake_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKE) |=> (state == ST_RUN));
endmodule

// File: rtl/scs_datapath.sv
module scs_datapath
  import scs_pkg::*;
#(
  parameter int NUM_CORE    = 3,
  parameter int NUM_INT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stopReqAsync,
  input  logic [NUM_INT-1:0]  intReq,
  input  logic [NUM_INT-1:0]  intAck,
  input  scsStrobe_t          strobe,
  output logic                stopSync,
  output logic [NUM_CORE-1:0] coreClkEn,
  output logic [NUM_INT-1:0]  pendingInt,
  output logic                intValid
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[LAST_STAGE-1:0], stopReqAsync};
  end
  assign stopSync = syncQ[LAST_STAGE];

  always_ff @(posedge clk) begin
    if (!rstN) coreClkEn <= '1;
    else       coreClkEn <= {NUM_CORE{strobe.coreOn}};
  end

  for (genvar i = 0; i < NUM_INT; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN)
        pendingInt[i] <= 1'b0;
      else
        pendingInt[i] <= intReq[i] | (pendingInt[i] & ~(intAck[i] & strobe.clearOk));
    end

    // R5
    capture_chk: assert property (@(posedge clk) disable iff (!rstN)
      intReq[i] |=> pendingInt[i]);

    // R6
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pendingInt[i] && !(intAck[i] && strobe.clearOk)) |=> pendingInt[i]);
  end

  assign intValid = strobe.serviceOk & (|pendingInt);

  // R3
  core_uniform_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreClkEn == '0) || (coreClkEn == '1));
endmodule

// File: rtl/scs_top.sv
module scs_top
  import scs_pkg::*;
#(
  parameter int NUM_CORE    = 3,
  parameter int NUM_INT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stopReqAsync,
  input  logic                busDone,
  input  logic [NUM_INT-1:0]  intReq,
  input  logic [NUM_INT-1:0]  intAck,
  output logic                ackReq,
  output logic [NUM_CORE-1:0] coreClkEn,
  output logic                busClkEn,
  output logic                intcClkEn,
  output logic                snoopEn,
  output logic [NUM_INT-1:0]  pendingInt,
  output logic                intValid
);
  scsStrobe_t strobe;
  logic       stopSync;

  scs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stopSync (stopSync),
    .busDone  (busDone),
    .ackReq   (ackReq),
    .strobe   (strobe)
  );

  scs_datapath #(
    .NUM_CORE    (NUM_CORE),
    .NUM_INT     (NUM_INT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stopReqAsync (stopReqAsync),
    .intReq       (intReq),
    .intAck       (intAck),
    .strobe       (strobe),
    .stopSync     (stopSync),
    .coreClkEn    (coreClkEn),
    .pendingInt   (pendingInt),
    .intValid     (intValid)
  );

  // R4: bus, interrupt-controller and snoop enables never drop
  assign busClkEn  = 1'b1;
  assign intcClkEn = 1'b1;
  assign snoopEn   = 1'b1;

  // R3
  core_off_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreClkEn[0]) |-> $past(ackReq && busDone));
endmodule

// File: tb/tb_scs_top.sv
module tb_scs_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stopReqAsync = 1'b0;
  logic       busDone = 1'b0;
  logic [3:0] intReq = '0;
  logic [3:0] intAck = '0;
  logic       ackReq, busClkEn, intcClkEn, snoopEn, intValid;
  logic [2:0] coreClkEn;
  logic [3:0] pendingInt;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  scs_top dut (
    .clk(clk), .rstN(rstN), .stopReqAsync(stopReqAsync), .busDone(busDone),
    .intReq(intReq), .intAck(intAck), .ackReq(ackReq), .coreClkEn(coreClkEn),
    .busClkEn(busClkEn), .intcClkEn(intcClkEn), .snoopEn(snoopEn),
    .pendingInt(pendingInt), .intValid(intValid)
  );

  // fields: stop | done | req[3:0] | ack[3:0] | expAck | expCore | expValid | expPend[3:0]
  localparam int NVEC = 14;
  localparam logic [16:0] VEC [NVEC] = '{
    17'b1_0_0000_0000_0_1_0_0000, // R1 sync stage 1
    17'b1_0_0000_0000_0_1_0_0000, // R1 sync stage 2
    17'b1_0_0000_0000_1_1_0_0000, // R1 acknowledge begins
    17'b1_0_0001_0000_1_1_0_0001, // R2 held, R5 capture
    17'b1_1_0000_0000_0_0_0_0001, // R2 drop, R3 core off
    17'b1_0_0100_0001_0_0_0_0101, // R6 ack ignored while stopped
    17'b0_0_0000_0000_0_0_0_0101, // R7 release sync 1
    17'b0_0_0000_0000_0_0_0_0101, // R7 release sync 2
    17'b0_0_0000_0000_0_1_0_0101, // R7 wake step
    17'b0_0_0000_0000_0_1_1_0101, // R7 run, service
    17'b0_0_0000_0100_0_1_1_0001, // R6 clear bit 2
    17'b0_0_0010_0001_0_1_1_0010, // R6 clear bit 0, R5 set bit 1
    17'b0_0_0010_0010_0_1_1_0010, // R6 request wins
    17'b0_0_0000_0010_0_1_0_0000  // R6 clear, R7 valid drops
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAlwaysOn();
    // R4
    check(busClkEn && intcClkEn && snoopEn, "R4",
          {busClkEn, intcClkEn, snoopEn}, 3'b111);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9 reset state, with requests ignored during reset
    intReq = 4'b1111;
    repeat (3) @(posedge clk);
    #2;
    check(!ackReq && !intValid, "R9", {ackReq, intValid}, 0);
    check(pendingInt == 4'b0000, "R9", pendingInt, 0);
    check(coreClkEn == 3'b111, "R9", coreClkEn, 3'b111);
    checkAlwaysOn();
    @(negedge clk);
    intReq = '0;
    rstN = 1'b1;

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      stopReqAsync = VEC[i][16];
      busDone      = VEC[i][15];
      intReq       = VEC[i][14:11];
      intAck       = VEC[i][10:7];
      @(posedge clk);
      #2;
      check(ackReq == VEC[i][6], "R1/R2 ackReq", ackReq, VEC[i][6]);
      check(coreClkEn == {3{VEC[i][5]}}, "R3/R7 coreClkEn", coreClkEn, {3{VEC[i][5]}});
      check(intValid == VEC[i][4], "R7 intValid", intValid, VEC[i][4]);
      check(pendingInt == VEC[i][3:0], "R5/R6 pendingInt", pendingInt, VEC[i][3:0]);
      checkAlwaysOn();
      @(negedge clk);
    end
    stopReqAsync = 1'b0; busDone = 1'b0; intReq = '0; intAck = '0;

    // R8: release before the acknowledge completes
    stopReqAsync = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(ackReq == 1'b1, "R8 ack start", ackReq, 1);
    @(negedge clk);
    stopReqAsync = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      #2;
      check(ackReq == 1'b1, "R8 ack held", ackReq, 1);
      check(coreClkEn == 3'b111, "R8 core on", coreClkEn, 3'b111);
    end
    @(negedge clk);
    busDone = 1'b1;
    @(posedge clk);
    #2;
    check(ackReq == 1'b0, "R8 ack done", ackReq, 0);
    check(coreClkEn == 3'b111, "R8 core never off", coreClkEn, 3'b111);
    @(negedge clk);
    busDone = 1'b0;
    repeat (3) begin
      @(posedge clk);
      #2;
      check(ackReq == 1'b0, "R2 single ack", ackReq, 0);
      check(coreClkEn == 3'b111, "R8 run", coreClkEn, 3'b111);
      checkAlwaysOn();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule